// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM from power-on to a programmed, ready state. After reset it holds the clock-enable and data-mask pins high and keeps the command pins at NOP. It then waits for a start request. When start is sampled, the block captures the configuration fields. If the configuration is legal, it counts out a stabilization interval of at least 200 µs. The length of that interval in cycles comes from a clock-frequency parameter.

After the interval, the block issues one precharge covering every bank. It then issues a parameterised number of auto-refresh commands and one mode-register set. A configuration bit chooses whether the mode set comes before the refreshes or after them. Every command is followed by a programmable gap, and the command pins show NOP for the whole gap. Once the last gap has run out, the block raises done and stays idle.

The mode word is built from the requested burst length, burst type, read latency and write-burst mode. A configuration that uses a reserved code, or that asks for a full-page burst with interleaved order, is rejected at start. The rejection raises the error flag, and no command is sent.

Top module: `sdram_powerup_seq`

## Requirements
- R1: Out of reset, cke and dqm are 1, the command pins {cs_n,ras_n,cas_n,we_n} show NOP (4'b0111), addr and ba are all zero, and done and cfg_err are 0.
- R2: When start is sampled with a legal configuration, the command pins stay NOP for exactly CLK_MHZ*200 cycles. A precharge then follows (4'b0010) with addr bit 10 set and all other addr bits zero.
- R3: Exactly REFRESH_COUNT auto-refresh commands (4'b0001) are issued, with T_RC cycles between consecutive refreshes.
- R4: With cfg_mode_first=0, the first refresh comes T_RP cycles after the precharge. The mode set (4'b0000) comes T_RC cycles after the last refresh, and done rises T_MRD cycles after the mode set.
- R5: With cfg_mode_first=1, the mode set comes T_RP cycles after the precharge. The first refresh comes T_MRD cycles after the mode set, and done rises T_RC cycles after the last refresh.
- R6: During the mode set, addr[2:0] holds the burst-length code and addr[3] the burst type (0 sequential, 1 interleaved). addr[6:4] holds the latency code and addr[9] the single-location-write bit. addr[8:7], addr[11:10], all higher addr bits and ba are 0.
- R7: The burst-length codes 3'b100, 3'b101 and 3'b110 are rejected: cfg_err rises, the command pins stay NOP and done stays 0.
- R8: Burst-length code 3'b111 (full page) is accepted with sequential type and rejected with interleaved type.
- R9: Only the latency codes 3'b010 and 3'b011 are accepted; every other code is rejected in the same way as R7.
- R10: Every cycle between commands shows NOP. Once done is high it stays high with NOP on the command pins, and a later start is ignored.
- R11: Any two commands are at least two cycles apart, with NOP between them.
- R12: While cfg_err is high, a start with a legal configuration clears cfg_err and runs the full sequence.
- R13: Configuration inputs that change after start is sampled have no effect on the mode word or on the command order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the initialization sequence |
| cfg_burst_len | input | 3 | Burst-length code |
| cfg_interleave | input | 1 | Burst type: 1 for interleaved |
| cfg_cas_lat | input | 3 | Read-latency code |
| cfg_single_write | input | 1 | Burst read with single-location write |
| cfg_mode_first | input | 1 | Issue the mode set before the refreshes |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| dqm | output | 1 | Data mask |
| addr | output | ADDR_W | Address bus |
| ba | output | BANK_W | Bank select |
| done | output | 1 | Initialization complete |
| cfg_err | output | 1 | Configuration rejected |

## Verification
The bench builds the block with CLK_MHZ=1, so the stabilization wait is 200 cycles. That keeps every scenario short enough to compare cycle by cycle against a schedule computed in the bench. REFRESH_COUNT=3 brings the middle refresh and the refresh-to-refresh spacing into view, which the minimum count of two would not show. The gaps T_RP=3, T_RC=5 and T_MRD=2 all differ from one another, so a gap counter loaded with the wrong value, or a mode set placed on the wrong side of the refreshes, moves an observed command to a different cycle.

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq #(
  parameter int CLK_MHZ       = 100,
  parameter int WAIT_US       = 200,
  parameter int REFRESH_COUNT = 2,
  parameter int T_RP          = 3,
  parameter int T_RC          = 9,
  parameter int T_MRD         = 2,
  parameter int ADDR_W        = 12,
  parameter int BANK_W        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_single_write,
  input  logic              cfg_mode_first,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke,
  output logic              dqm,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              done,
  output logic              cfg_err
);
  localparam int STABLE_CYC = CLK_MHZ * WAIT_US;
  localparam int GAP_MAX    = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                            : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int CNT_MAX    = (STABLE_CYC > GAP_MAX) ? STABLE_CYC : GAP_MAX;
  localparam int CW         = $clog2(CNT_MAX + 1);
  localparam int RW         = $clog2(REFRESH_COUNT + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_PRE, S_REF, S_MRS, S_GAP, S_DONE, S_ERR
  } st_t;

  st_t           state, after;
  logic [CW-1:0] cnt;
  logic [RW-1:0] refs;
  logic [9:0]    mode_q;
  logic          mf_q;

  wire       bl_ok    = !cfg_burst_len[2] || (cfg_burst_len == 3'b111 && !cfg_interleave);
  wire       cl_ok    = (cfg_cas_lat == 3'b010) || (cfg_cas_lat == 3'b011);
  wire [9:0] mode_in  = {cfg_single_write, 2'b00, cfg_cas_lat, cfg_interleave, cfg_burst_len};
  wire       last_ref = (refs + 1'b1) == RW'(REFRESH_COUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      after  <= S_IDLE;
      cnt    <= '0;
      refs   <= '0;
      mode_q <= '0;
      mf_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_ERR:
          if (start) begin
            mode_q <= mode_in;
            mf_q   <= cfg_mode_first;
            refs   <= '0;
            if (bl_ok && cl_ok) begin
              state <= S_WAIT;
              cnt   <= CW'(STABLE_CYC - 1);
            end else begin
              state <= S_ERR;
            end
          end
        S_WAIT:
          if (cnt == '0) state <= S_PRE;
          else           cnt   <= cnt - 1'b1;
        S_PRE: begin
          cnt   <= CW'(T_RP - 2);
          after <= mf_q ? S_MRS : S_REF;
          state <= S_GAP;
        end
        S_REF: begin
          cnt   <= CW'(T_RC - 2);
          refs  <= refs + 1'b1;
          after <= !last_ref ? S_REF : (mf_q ? S_DONE : S_MRS);
          state <= S_GAP;
        end
        S_MRS: begin
          cnt   <= CW'(T_MRD - 2);
          after <= mf_q ? S_REF : S_DONE;
          state <= S_GAP;
        end
        S_GAP:
          if (cnt == '0) state <= after;
          else           cnt   <= cnt - 1'b1;
        default: state <= state;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = (state == S_PRE) ? 4'b0010 :
                                      (state == S_REF) ? 4'b0001 :
                                      (state == S_MRS) ? 4'b0000 : 4'b0111;

  assign addr    = (state == S_MRS) ? ADDR_W'(mode_q) :
                   (state == S_PRE) ? ADDR_W'(1 << 10) : '0;
  assign ba      = '0;
  assign cke     = 1'b1;
  assign dqm     = 1'b1;
  assign done    = (state == S_DONE);
  assign cfg_err = (state == S_ERR);
endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] ba,
  input logic              done,
  input logic              cfg_err
);
  wire [3:0] cmd    = {cs_n, ras_n, cas_n, we_n};
  wire       is_nop = (cmd == 4'b0111);
  wire       is_mrs = (cmd == 4'b0000);

  assert_known_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd inside {4'b0111, 4'b0010, 4'b0001, 4'b0000});
  assert_pre_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> addr[10]);
  assert_nop_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop |-> (addr == '0));
  assert_mode_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (addr[8:7] == 2'b00 && addr[11:10] == 2'b00 && ba == '0));
  assert_mode_bl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (!addr[2] || addr[3:0] == 4'b0111));
  assert_mode_cl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (addr[6:4] == 3'b010 || addr[6:4] == 3'b011));
  assert_done_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> is_nop);
  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  assert_cmd_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |=> is_nop);
  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (is_nop && !done));
  assert_err_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !start) |=> cfg_err);
endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .done(done), .cfg_err(cfg_err)
);

// File: tb/sim_sdram_powerup_seq.sv
module sim_sdram_powerup_seq;
  localparam int S    = 200;
  localparam int RC   = 3;
  localparam int TRP  = 3;
  localparam int TRC  = 5;
  localparam int TMRD = 2;

  logic clk = 1'b0;
  logic rst_n, start, cfg_interleave, cfg_single_write, cfg_mode_first;
  logic [2:0] cfg_burst_len, cfg_cas_lat;
  logic cs_n, ras_n, cas_n, we_n, cke, dqm, done, cfg_err;
  logic [11:0] addr;
  logic [1:0]  ba;
  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  sdram_powerup_seq #(.CLK_MHZ(1), .WAIT_US(200), .REFRESH_COUNT(RC), .T_RP(TRP),
                      .T_RC(TRC), .T_MRD(TMRD), .ADDR_W(12), .BANK_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_burst_len(cfg_burst_len),
    .cfg_interleave(cfg_interleave), .cfg_cas_lat(cfg_cas_lat),
    .cfg_single_write(cfg_single_write), .cfg_mode_first(cfg_mode_first),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke), .dqm(dqm),
    .addr(addr), .ba(ba), .done(done), .cfg_err(cfg_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [3:0] cmd();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    cfg_burst_len = 3'b011; cfg_interleave = 1'b0; cfg_cas_lat = 3'b010;
    cfg_single_write = 1'b0; cfg_mode_first = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd() == 4'b0111 && cke && dqm, "R1", {cke, dqm, cmd()}, 6'h37);
    chk(addr == 0 && ba == 0 && !done && !cfg_err, "R1", {done, cfg_err, ba, addr}, 0);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // expected command at sample n after start: 0 nop, 1 pre, 2 ref, 3 mrs
  function automatic int exp_cmd(input int n, input bit mf);
    int t = S + TRP;
    if (n == S) return 1;
    if (!mf) begin
      for (int i = 0; i < RC; i++) if (n == t + i * TRC) return 2;
      if (n == t + RC * TRC) return 3;
    end else begin
      if (n == t) return 3;
      for (int i = 0; i < RC; i++) if (n == t + TMRD + i * TRC) return 2;
    end
    return 0;
  endfunction

  task automatic run_legal(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                           input logic sw, input logic mf, input bit scramble);
    int done_t = mf ? S + TRP + TMRD + RC * TRC : S + TRP + RC * TRC + TMRD;
    logic [11:0] mword = {2'b00, sw, 2'b00, cl, bt, bl};
    int nref = 0;
    string rq = mf ? "R5" : "R4";
    do_reset();
    cfg_burst_len = bl; cfg_interleave = bt; cfg_cas_lat = cl;
    cfg_single_write = sw; cfg_mode_first = mf;
    pulse_start();
    if (scramble) begin  // R13: inputs changed after start is sampled
      cfg_burst_len = 3'b101; cfg_interleave = ~bt; cfg_cas_lat = 3'b000;
      cfg_single_write = ~sw; cfg_mode_first = ~mf;
    end
    for (int n = 0; n <= done_t + 3; n++) begin
      int e = exp_cmd(n, mf);
      logic [3:0] ec = (e == 1) ? 4'b0010 : (e == 2) ? 4'b0001 : (e == 3) ? 4'b0000 : 4'b0111;
      if (e == 2) nref++;
      chk(cmd() == ec, n <= S ? "R2" : (scramble ? "R13" : rq), cmd(), ec);
      chk(cke && dqm && !cfg_err, "R1", {cke, dqm, cfg_err}, 3'b110);
      chk(done == (n >= done_t), n >= done_t ? "R10" : rq, done, n >= done_t);
      if (e == 1) chk(addr == 12'h400, "R2", addr, 12'h400);
      if (e == 3) chk(addr == mword && ba == 0, scramble ? "R13" : "R6", addr, mword);
      if (e == 0) chk(addr == 0, "R10", addr, 0);
      @(negedge clk);
    end
    chk(nref == RC, "R3", nref, RC);
    cfg_burst_len = 3'b001; cfg_mode_first = 1'b0;
    pulse_start();
    for (int n = 0; n < 20; n++) begin
      chk(done && cmd() == 4'b0111, "R10", {done, cmd()}, 5'h17);
      @(negedge clk);
    end
  endtask

  task automatic run_illegal(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                             input string rq);
    do_reset();
    cfg_burst_len = bl; cfg_interleave = bt; cfg_cas_lat = cl;
    pulse_start();
    for (int n = 0; n < 30; n++) begin
      chk(cfg_err && !done && cmd() == 4'b0111, rq, {cfg_err, done, cmd()}, 6'h27);
      @(negedge clk);
    end
    cfg_burst_len = 3'b010; cfg_interleave = 1'b0; cfg_cas_lat = 3'b011;
    pulse_start();
    chk(!cfg_err, "R12", cfg_err, 0);
    for (int n = 1; n <= S; n++) begin
      @(negedge clk);
      if (n == S) chk(cmd() == 4'b0010, "R12", cmd(), 4'b0010);
      else if (cmd() != 4'b0111) chk(1'b0, "R12", cmd(), 4'b0111);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog expired: actual=%0d expected<100000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    run_legal(3'b011, 1'b0, 3'b010, 1'b0, 1'b0, 1'b0);
    run_legal(3'b111, 1'b0, 3'b011, 1'b1, 1'b1, 1'b0);  // R8 full page sequential
    run_legal(3'b000, 1'b1, 3'b011, 1'b1, 1'b0, 1'b1);
    run_illegal(3'b100, 1'b0, 3'b010, "R7");
    run_illegal(3'b101, 1'b0, 3'b010, "R7");
    run_illegal(3'b110, 1'b1, 3'b011, "R7");
    run_illegal(3'b111, 1'b1, 3'b010, "R8");
    run_illegal(3'b001, 1'b0, 3'b000, "R9");
    run_illegal(3'b001, 1'b0, 3'b001, "R9");
    run_illegal(3'b010, 1'b1, 3'b100, "R9");
    run_illegal(3'b010, 1'b0, 3'b111, "R9");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule